// File: doc/BRIEF.md
# Frequency-Adjustable Nanosecond Time Counter

This block keeps a 44-bit nanosecond time of day for precision time protocol use. It works as a numerically controlled oscillator. A 72-bit accumulator holds the nanosecond count above 28 bits of fractional nanosecond. On every reference clock cycle it adds a 32-bit increment, and the carry out of the top bit is dropped. At a 125 MHz reference, the reset increment of 0x8000_0000 advances time by exactly 8 ns per cycle. One nanosecond equals 2^28 increment units, so software trims the rate by adding to or subtracting from that nominal value. The usable trim range is about ±50,000,000 ppb.

Software reaches the counter through a simple 32-bit register port. The port has a single-cycle valid/write-enable strobe and a 4-bit byte address. Bits [3:2] of the address pick one of four words:
- word 0x0 holds nanosecond bits [3:0];
- word 0x4 holds nanosecond bits [35:4];
- word 0x8 holds nanosecond bits [43:36], read from bits [7:0] but written through bits [15:8];
- word 0xC holds the increment.

Read data is a combinational view of the current registers at the presented address. A write replaces one field on the next clock edge and takes precedence over that cycle's increment. Writing an increment of zero holds the time.

Top module: `time_nco_top`

## Requirements
- R1: While reset is asserted, the time reads as zero and the increment word (address 0xC) reads 0x8000_0000.
- R2: When no time field is being written, each clock edge adds the 32-bit increment, zero-extended, to the 72-bit value {ns[43:0], frac[27:0]}. Fractional parts carry into the nanosecond bits, so the default increment gives 8 ns per cycle and 0x0800_0000 gives 0.5 ns per cycle.
- R3: Address bits [3:2] select the word and bits [1:0] are ignored. The reads are:
  - word 0 returns ns[3:0] in bits [3:0];
  - word 1 returns ns[35:4];
  - word 2 returns ns[43:36] in bits [7:0];
  - word 3 returns the increment.
  Unused read bits are zero, and on a write to word 0 only wdata bits [3:0] are used.
- R4: A write to word 2 loads ns[43:36] from wdata bits [15:8]; the other wdata bits have no effect.
- R5: A time-field write replaces only that field and leaves the other fields and the fractional bits unchanged. It appears after the same clock edge, and no increment is added on that edge.
- R6: With an increment of zero the time holds; writing a nonzero increment resumes counting from the held value.
- R7: Time wraps from 2^44-1 ns to 0, and the carry is discarded.
- R8: The increment word changes only on a valid write to address 0xC. Any 32-bit value is accumulated exactly, so a trimmed increment such as 0x8001_0000 or 0x7FFF_0000 shifts time by exactly one nanosecond every 4096 cycles.
- R9: A cycle with we_i high but valid_i low changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock (125 MHz) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Bus strobe for a write this cycle |
| we_i | input | 1 | Write enable, qualified by valid_i |
| addr_i | input | 4 | Byte address; bits [3:2] select the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word at addr_i |

## Verification
The bench builds the block with its default parameters: a 44-bit time, 28 fractional bits, a 32-bit increment and the 0x8000_0000 reset increment. With these values a 4096-cycle run with a trimmed increment lands on an exact one-nanosecond offset. A half-nanosecond increment exposes fractional carry into the visible low field within three cycles. Loading all-ones fields reaches the 44-bit wrap in two cycles instead of hours. The bench tracks the full 72-bit accumulator in its own model, so it can predict fractional bits that no register exposes.

// File: rtl/time_nco_pkg.sv
package time_nco_pkg;
  localparam int unsigned NS_W       = 44;
  localparam int unsigned FRAC_W     = 28;
  localparam int unsigned INC_W      = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned LO_W       = 4;
  localparam int unsigned MID_W      = 32;
  localparam int unsigned HI_W       = NS_W - LO_W - MID_W;
  localparam int unsigned HI_WR_LSB  = 8;
  localparam int unsigned ACC_W      = NS_W + FRAC_W;

  // word order follows the address map
  typedef enum logic [1:0] {
    SEL_LO  = 2'd0,
    SEL_MID = 2'd1,
    SEL_HI  = 2'd2,
    SEL_INC = 2'd3
  } word_sel_e;
endpackage

// File: rtl/time_nco_decode.sv
module time_nco_decode
  import time_nco_pkg::*;
#(
  parameter logic [INC_W-1:0] INC_RESET = 32'h8000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output word_sel_e         sel_o,
  output logic              ld_lo_o,
  output logic              ld_mid_o,
  output logic              ld_hi_o,
  output logic [INC_W-1:0]  inc_o
);
  logic wr_en;
  logic [1:0] unused_addr;
  logic [INC_W-1:0] inc_q;

  assign unused_addr = addr_i[1:0];
  assign sel_o    = word_sel_e'(addr_i[3:2]);
  assign wr_en    = valid_i && we_i;
  assign ld_lo_o  = wr_en && (sel_o == SEL_LO);
  assign ld_mid_o = wr_en && (sel_o == SEL_MID);
  assign ld_hi_o  = wr_en && (sel_o == SEL_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        inc_q <= INC_RESET;
    else if (wr_en && sel_o == SEL_INC) inc_q <= wdata_i[INC_W-1:0];
  end

  assign inc_o = inc_q;

  // R8: increment register only moves on a strobed write to its word
  p_inc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && we_i && addr_i[3:2] == 2'd3) |=> $stable(inc_o));
endmodule

// File: rtl/time_nco_accum.sv
module time_nco_accum
  import time_nco_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_lo_i,
  input  logic              ld_mid_i,
  input  logic              ld_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [INC_W-1:0]  inc_i,
  output logic [NS_W-1:0]   ns_o
);
  localparam int unsigned MID_LSB = LO_W;
  localparam int unsigned HI_LSB  = LO_W + MID_W;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [NS_W-1:0]  ns_ld;
  logic             any_ld;

  assign any_ld = ld_lo_i | ld_mid_i | ld_hi_i;

  always_comb begin
    ns_ld = acc_q[ACC_W-1:FRAC_W];
    if (ld_lo_i)  ns_ld[LO_W-1:0]         = wdata_i[LO_W-1:0];
    if (ld_mid_i) ns_ld[HI_LSB-1:MID_LSB] = wdata_i[MID_W-1:0];
    if (ld_hi_i)  ns_ld[NS_W-1:HI_LSB]    = wdata_i[HI_WR_LSB+HI_W-1:HI_WR_LSB];
    // field writes win over the increment; top carry dropped on add
    if (any_ld) acc_d = {ns_ld, acc_q[FRAC_W-1:0]};
    else        acc_d = acc_q + {{(ACC_W-INC_W){1'b0}}, inc_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign ns_o = acc_q[ACC_W-1:FRAC_W];

  // R6: zero increment holds time
  p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_ld && inc_i == '0) |=> $stable(acc_q));
  // R5: field writes never disturb the fraction
  p_frac_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ld |=> acc_q[FRAC_W-1:0] == $past(acc_q[FRAC_W-1:0]));
  // R5: low-field write leaves the upper fields alone
  p_lo_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo_i && !ld_mid_i && !ld_hi_i) |=>
      (ns_o[NS_W-1:LO_W] == $past(ns_o[NS_W-1:LO_W])) &&
      (ns_o[LO_W-1:0] == $past(wdata_i[LO_W-1:0])));
endmodule

// File: rtl/time_nco_rdmux.sv
module time_nco_rdmux
  import time_nco_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  word_sel_e         sel_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic [INC_W-1:0]  inc_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_LO:  rdata_o[LO_W-1:0]  = ns_i[LO_W-1:0];
      SEL_MID: rdata_o[MID_W-1:0] = ns_i[LO_W+MID_W-1:LO_W];
      SEL_HI:  rdata_o[HI_W-1:0]  = ns_i[NS_W-1:LO_W+MID_W];
      SEL_INC: rdata_o[INC_W-1:0] = inc_i;
      default: rdata_o = '0;
    endcase
  end

  // R3: unused read bits stay zero
  p_lo_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_LO) |-> rdata_o[DATA_W-1:LO_W] == '0);
  p_hi_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_HI) |-> rdata_o[DATA_W-1:HI_W] == '0);
endmodule

// File: rtl/time_nco_top.sv
module time_nco_top
  import time_nco_pkg::*;
#(
  parameter logic [INC_W-1:0] INC_RESET = 32'h8000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  word_sel_e        sel;
  logic             ld_lo, ld_mid, ld_hi;
  logic [INC_W-1:0] inc;
  logic [NS_W-1:0]  ns;

  time_nco_decode #(.INC_RESET(INC_RESET)) i_decode (
    .clk_i, .rst_ni, .valid_i, .we_i, .addr_i, .wdata_i,
    .sel_o(sel), .ld_lo_o(ld_lo), .ld_mid_o(ld_mid), .ld_hi_o(ld_hi), .inc_o(inc)
  );

  time_nco_accum i_accum (
    .clk_i, .rst_ni, .ld_lo_i(ld_lo), .ld_mid_i(ld_mid), .ld_hi_i(ld_hi),
    .wdata_i, .inc_i(inc), .ns_o(ns)
  );

  time_nco_rdmux i_rdmux (
    .clk_i, .rst_ni, .sel_i(sel), .ns_i(ns), .inc_i(inc), .rdata_o
  );
endmodule

// File: tb/test_time_nco_top.sv
`timescale 1ns/1ps
module test_time_nco_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [71:0] m;               // model: {ns[43:0], frac[27:0]}
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  time_nco_top i_time_nco_top (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [31:0] mword(input logic [1:0] s);
    case (s)
      2'd0:    return {28'd0, m[31:28]};
      2'd1:    return m[63:32];
      2'd2:    return {24'd0, m[71:64]};
      default: return 32'hxxxx_xxxx;
    endcase
  endfunction

  // scoreboard monitor: compares pushed expectations just after each negedge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() != 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string t, input bit wait_edge);
    if (wait_edge) @(negedge clk);
    addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic field_write(input logic [3:0] a, input logic [31:0] d);
    bus_write(a, d);
    case (a[3:2])
      2'd0: m[31:28] = d[3:0];
      2'd1: m[63:32] = d;
      2'd2: m[71:64] = d[15:8];
      default: ;
    endcase
  endtask

  // n adds of x (n >= 2), then frozen
  task automatic run(input logic [31:0] x, input int n);
    bus_write(4'hC, x);
    repeat (n - 2) @(negedge clk);
    bus_write(4'hC, 32'd0);
    m = m + ({40'd0, x} * 72'(n));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(4'hC, 32'h8000_0000, "R1 inc reset", 1);
    chk(4'h4, 32'd0, "R1 time reset", 1);
    @(negedge clk);
    rst_ni = 1'b1;
    // R2 default 8 ns per cycle
    chk(4'h0, 32'd8, "R2 ns after 1 cycle", 1);
    chk(4'h4, 32'd1, "R2 ns after 2 cycles", 1);
    chk(4'h8, 32'd0, "R3 upper word after 3 cycles", 1);
    // R5 write wins over increment on that edge
    bus_write(4'h0, 32'd3);
    chk(4'h0, 32'd3, "R5 write priority", 0);
    bus_write(4'hC, 32'd0);
    m = '0;
    // R3/R4 field loads and layout
    field_write(4'h0, 32'hFFFF_FFF5);
    field_write(4'h4, 32'h1234_5678);
    field_write(4'h8, 32'h0000_AB77);
    chk(4'h0, 32'd5, "R3 low word", 1);
    chk(4'h4, 32'h1234_5678, "R3 mid word", 1);
    chk(4'h8, 32'h0000_00AB, "R4 upper write from [15:8]", 1);
    chk(4'hC, 32'd0, "R8 inc readback zero", 1);
    chk(4'h5, 32'h1234_5678, "R3 addr low bits ignored", 1);
    // R6 frozen
    repeat (5) @(negedge clk);
    chk(4'h4, mword(2'd1), "R6 hold with zero inc", 1);
    // R9 write without valid
    @(negedge clk);
    valid = 1'b0; we = 1'b1; addr = 4'h4; wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    we = 1'b0;
    chk(4'h4, 32'h1234_5678, "R9 unstrobed write ignored", 0);
    // R2 fractional carry, R6 resume
    run(32'h0800_0000, 3);
    chk(4'h0, mword(2'd0), "R6 resume 1.5ns", 1);
    run(32'h0800_0000, 2);
    chk(4'h0, mword(2'd0), "R2 frac 2.5ns", 1);
    run(32'h0800_0000, 3);
    chk(4'h0, 32'd9, "R2 frac carry to 4.0ns", 1);
    // R5 fraction survives a field write
    run(32'h0800_0000, 3);
    field_write(4'h0, 32'd0);
    run(32'h0800_0000, 3);
    chk(4'h0, 32'd2, "R5 frac kept over low write", 1);
    // R8 trimmed increments
    run(32'h8001_0000, 4096);
    chk(4'h0, mword(2'd0), "R8 trim up low", 1);
    chk(4'h4, mword(2'd1), "R8 trim up mid", 1);
    run(32'h7FFF_0000, 4096);
    chk(4'h0, mword(2'd0), "R8 trim down low", 1);
    chk(4'h4, mword(2'd1), "R8 trim down mid", 1);
    // R7 wrap
    field_write(4'h8, 32'h0000_FF00);
    field_write(4'h4, 32'hFFFF_FFFF);
    field_write(4'h0, 32'h0000_000F);
    run(32'h8000_0000, 2);
    chk(4'h0, mword(2'd0), "R7 wrap low", 1);
    chk(4'h4, 32'd0, "R7 wrap mid", 1);
    chk(4'h8, 32'd0, "R7 wrap upper", 1);
    // R8 increment readback
    bus_write(4'hC, 32'h8123_4567);
    chk(4'hC, 32'h8123_4567, "R8 inc readback", 0);
    bus_write(4'hC, 32'd0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule